// File: doc/BRIEF.md
# Per-Channel Silence Flag Detector

This block watches the left and right input streams of a converter and raises a flag for each channel once that channel has been silent for long enough. There are two kinds of stream. In the two word-based modes, silence is an unbroken run of all-zero samples. In the one-bit stream mode, silence is a repeating mute byte held for roughly 22 ms. The number of items needed before a flag goes active depends on the mode. A single configuration pin chooses whether the flag pins are active high or active low.

Samples arrive on one valid/ready port that carries both channels in each beat. Bits arrive on a second valid/ready port that carries one bit per channel in each beat. The block never applies back-pressure, so both ready outputs are held high and a beat is accepted on every cycle where its valid is high. A beat on the port that the current mode does not use is accepted and then discarded. The block produces flags only. It does not mute the audio path.

Top module: `zero_mute_detect`

## Requirements
- R1: While reset is asserted and after it is released, both counters are zero and both flag pins sit at their inactive level. The inactive level is 0 when `flag_active_low`=0 and 1 when `flag_active_low`=1.
- R2: In word mode `mode`=2'b00, or in the reserved value 2'b11, which behaves the same way, a channel's flag becomes active on the accepted beat that completes 1024 consecutive zero samples on that channel. It is still inactive after 1023.
- R3: In oversampled-filter mode `mode`=2'b01, the threshold is 8192 consecutive zero samples.
- R4: In bitstream mode `mode`=2'b10, bits are taken MSB first into bytes. Byte boundaries count from reset or from the last mode change. A channel's flag becomes active on the bit that completes 7776 consecutive bytes equal to 8'h69.
- R5: A nonzero sample, or a completed byte other than 8'h69, clears that channel's counter and deasserts its flag at the edge that accepts it.
- R6: Once a counter reaches its threshold it saturates. Further silent items keep the flag active and the count never wraps.
- R7: With `flag_active_low`=1 an active flag drives its pin low. With `flag_active_low`=0 an active flag drives its pin high. A change of this pin takes effect immediately.
- R8: The two channels count independently. Activity on one channel never changes the other channel's flag.
- R9: The clock edge at which `mode` differs from its value at the previous edge clears both counters and the byte alignment, and it accepts no item.
- R10: Beats on the port that the current mode does not use have no effect. `pcm_ready` and `dsd_ready` are always 1, so a beat is accepted whenever its valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 word, 01 oversampled filter, 10 bitstream, 11 as 00 |
| flag_active_low | input | 1 | 1 makes the flag pins active low |
| pcm_valid | input | 1 | Sample beat valid |
| pcm_ready | output | 1 | Sample beat ready, always 1 |
| pcm_left | input | SAMPLE_W | Left sample, two's complement |
| pcm_right | input | SAMPLE_W | Right sample, two's complement |
| dsd_valid | input | 1 | Bit beat valid |
| dsd_ready | output | 1 | Bit beat ready, always 1 |
| dsd_left | input | 1 | Left stream bit |
| dsd_right | input | 1 | Right stream bit |
| zero_left | output | 1 | Left silence flag |
| zero_right | output | 1 | Right silence flag |

## Verification
Every counter update lands at the clock edge that accepts the beat, and the flag pins follow the counters through logic alone. A result is therefore visible one cycle after the beat is presented, while a polarity change shows at once. The bench drives each beat just after a falling edge and queues the expected pin pair for that beat. The monitor compares the queued pair one time unit after the next rising edge, which is the earliest point where the edge that consumed the beat can show its effect. Mode changes queue a cleared, inactive pair in the same way.

// File: rtl/zmd_pkg.sv
package zmd_pkg;
  typedef enum logic [1:0] {
    ZM_WORD = 2'b00,
    ZM_OVS  = 2'b01,
    ZM_BITS = 2'b10,
    ZM_RSV  = 2'b11
  } zmd_mode_e;

  localparam logic [7:0] ZM_MUTE_BYTE = 8'h69;
endpackage

// File: rtl/zmd_byte_tracker.sv
module zmd_byte_tracker #(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] PATTERN = 8'h69
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_vld,
  input  logic bit_in,
  output logic byte_evt,
  output logic byte_match
);
  localparam int POS_W = $clog2(BYTE_W);

  logic [BYTE_W-2:0] shreg;
  logic [POS_W-1:0]  pos;

  assign byte_evt   = bit_vld && (pos == POS_W'(BYTE_W - 1));
  assign byte_match = ({shreg, bit_in} == PATTERN);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      shreg <= '0;
      pos   <= '0;
    end else if (bit_vld) begin
      shreg <= {shreg[BYTE_W-3:0], bit_in};
      pos   <= byte_evt ? '0 : pos + 1'b1;
    end
  end
endmodule

// File: rtl/zmd_run_counter.sv
module zmd_run_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             evt,
  input  logic             quiet,
  input  logic [CNT_W-1:0] limit,
  output logic             full
);
  logic [CNT_W-1:0] cnt;

  assign full = (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (evt) begin
      if (!quiet)            cnt <= '0;
      else if (cnt != limit) cnt <= cnt + 1'b1;
    end
  end

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && quiet && !clr && full) |=> full);

  assert_loud_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !quiet) |=> (cnt == '0));

  assert_rise_needs_item_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(evt && quiet));
endmodule

// File: rtl/zero_mute_detect.sv
module zero_mute_detect
  import zmd_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int WORD_LIMIT = 1024,
  parameter int OVS_LIMIT  = 8192,
  parameter int BITS_LIMIT = 7776
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode,
  input  logic                flag_active_low,
  input  logic                pcm_valid,
  output logic                pcm_ready,
  input  logic [SAMPLE_W-1:0] pcm_left,
  input  logic [SAMPLE_W-1:0] pcm_right,
  input  logic                dsd_valid,
  output logic                dsd_ready,
  input  logic                dsd_left,
  input  logic                dsd_right,
  output logic                zero_left,
  output logic                zero_right
);
  localparam int MAX_A = (WORD_LIMIT > OVS_LIMIT) ? WORD_LIMIT : OVS_LIMIT;
  localparam int MAX_L = (MAX_A > BITS_LIMIT) ? MAX_A : BITS_LIMIT;
  localparam int CNT_W = $clog2(MAX_L + 1);
  localparam int NCH   = 2;

  zmd_mode_e        mode_q;
  logic             mode_chg;
  logic             in_bits;
  logic [CNT_W-1:0] limit;
  logic             word_acc;
  logic             bit_acc;
  logic [NCH-1:0][SAMPLE_W-1:0] samp;
  logic [NCH-1:0]   bit_a;
  logic [NCH-1:0]   full_a;

  assign pcm_ready = 1'b1;
  assign dsd_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= ZM_WORD;
    else        mode_q <= zmd_mode_e'(mode);
  end

  assign mode_chg = (mode != mode_q);
  assign in_bits  = (mode_q == ZM_BITS);
  assign word_acc = pcm_valid && !in_bits && !mode_chg;
  assign bit_acc  = dsd_valid && in_bits && !mode_chg;

  always_comb begin
    unique case (mode_q)
      ZM_OVS:  limit = CNT_W'(OVS_LIMIT);
      ZM_BITS: limit = CNT_W'(BITS_LIMIT);
      default: limit = CNT_W'(WORD_LIMIT);
    endcase
  end

  assign samp  = {pcm_right, pcm_left};
  assign bit_a = {dsd_right, dsd_left};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic byte_evt, byte_match, evt, quiet;

    zmd_byte_tracker #(.BYTE_W(8), .PATTERN(ZM_MUTE_BYTE)) u_trk (
      .clk(clk), .rst_n(rst_n), .clr(mode_chg),
      .bit_vld(bit_acc), .bit_in(bit_a[ch]),
      .byte_evt(byte_evt), .byte_match(byte_match)
    );

    assign evt   = in_bits ? byte_evt : word_acc;
    assign quiet = in_bits ? byte_match : (samp[ch] == '0);

    zmd_run_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(mode_chg),
      .evt(evt), .quiet(quiet), .limit(limit), .full(full_a[ch])
    );
  end

  assign zero_left  = full_a[0] ^ flag_active_low;
  assign zero_right = full_a[1] ^ flag_active_low;

  assert_mode_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (full_a == '0));

  assert_idle_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_chg && !word_acc && !bit_acc) |=> $stable(full_a));
endmodule

// File: tb/sim_zero_mute_detect.sv
module sim_zero_mute_detect;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 24;
  localparam int WATCHDOG = 200000;

  typedef struct {
    logic  l;
    logic  r;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic pol = 1'b0;
  logic pcm_valid = 1'b0, dsd_valid = 1'b0;
  logic [SW-1:0] pcm_left = '0, pcm_right = '0;
  logic dsd_left = 1'b0, dsd_right = 1'b0;
  logic pcm_ready, dsd_ready, zero_left, zero_right;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  exp_t q[$];
  string cur_req = "R1";

  int m_cl = 0, m_cr = 0, m_pos = 0;
  logic [7:0] m_sl = '0, m_sr = '0;
  logic [1:0] m_mode = 2'b00;

  zero_mute_detect u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .flag_active_low(pol),
    .pcm_valid(pcm_valid), .pcm_ready(pcm_ready),
    .pcm_left(pcm_left), .pcm_right(pcm_right),
    .dsd_valid(dsd_valid), .dsd_ready(dsd_ready),
    .dsd_left(dsd_left), .dsd_right(dsd_right),
    .zero_left(zero_left), .zero_right(zero_right)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int thr();
    if (m_mode == 2'b01) return 8192;
    if (m_mode == 2'b10) return 7776;
    return 1024;
  endfunction

  function automatic int bump(input int c, input logic ok);
    if (!ok) return 0;
    return (c >= thr()) ? c : c + 1;
  endfunction

  function automatic exp_t model_out();
    exp_t e;
    e.l = (m_cl >= thr()) ^ pol;
    e.r = (m_cr >= thr()) ^ pol;
    e.req = cur_req;
    return e;
  endfunction

  task automatic drive(input logic pv, input logic [SW-1:0] pl, input logic [SW-1:0] pr,
                       input logic dv, input logic dl, input logic dr);
    @(negedge clk);
    pcm_valid = pv; pcm_left = pl; pcm_right = pr;
    dsd_valid = dv; dsd_left = dl; dsd_right = dr;
    if (m_mode != 2'b10) begin
      if (pv) begin
        m_cl = bump(m_cl, pl == '0);
        m_cr = bump(m_cr, pr == '0);
      end
    end else if (dv) begin
      m_sl = {m_sl[6:0], dl};
      m_sr = {m_sr[6:0], dr};
      m_pos++;
      if (m_pos == 8) begin
        m_pos = 0;
        m_cl = bump(m_cl, m_sl == 8'h69);
        m_cr = bump(m_cr, m_sr == 8'h69);
      end
    end
    q.push_back(model_out());
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m; m_mode = m;
    pcm_valid = 1'b0; dsd_valid = 1'b0;
    m_cl = 0; m_cr = 0; m_pos = 0; m_sl = '0; m_sr = '0;
    q.push_back(model_out());
  endtask

  task automatic set_pol(input logic p);
    @(negedge clk);
    pol = p; pcm_valid = 1'b0; dsd_valid = 1'b0;
    q.push_back(model_out());
  endtask

  task automatic words(input int n, input logic [SW-1:0] l, input logic [SW-1:0] r);
    for (int i = 0; i < n; i++) drive(1'b1, l, r, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic bytes_out(input int n, input logic [7:0] bl, input logic [7:0] br);
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) drive(1'b0, '0, '0, 1'b1, bl[b], br[b]);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (zero_left !== e.l || zero_right !== e.r || pcm_ready !== 1'b1 || dsd_ready !== 1'b1) begin
        errors++;
        $display("FAIL %s: flags l=%b r=%b rdy=%b%b, expected l=%b r=%b rdy=11",
                 e.req, zero_left, zero_right, pcm_ready, dsd_ready, e.l, e.r);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: run still going at cycle %0d, expected end before %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (zero_left !== 1'b0 || zero_right !== 1'b0) begin
      errors++;
      $display("FAIL R1: in reset l=%b r=%b, expected 0 0", zero_left, zero_right);
    end
    @(negedge clk); rst_n = 1'b1;
    cur_req = "R1"; drive(1'b0, '0, '0, 1'b0, 1'b0, 1'b0);

    cur_req = "R2"; words(1023, '0, '0);
    words(1, '0, '0);
    cur_req = "R6"; words(20, '0, '0);
    cur_req = "R5_R8"; words(1, 24'h000001, '0);
    words(5, '0, '0);
    cur_req = "R2"; words(1020, 24'h800000, '0);
    cur_req = "R2"; words(1030, '0, '0);

    cur_req = "R10"; bytes_out(2, 8'hFF, 8'h12);
    for (int i = 0; i < 30; i++) drive(1'b0, 24'h5, 24'h5, 1'b0, 1'b0, 1'b0);

    cur_req = "R7"; set_pol(1'b1);
    words(3, '0, 24'h7FFFFF);
    set_pol(1'b0);

    cur_req = "R9"; set_mode(2'b01);
    cur_req = "R3"; words(8191, '0, '0);
    words(2, '0, '0);
    cur_req = "R9"; set_mode(2'b11);
    cur_req = "R2"; words(1025, '0, '0);

    cur_req = "R9"; set_mode(2'b10);
    cur_req = "R10"; words(40, '0, '0);
    cur_req = "R4"; bytes_out(7775, 8'h69, 8'h69);
    bytes_out(1, 8'h69, 8'h69);
    cur_req = "R6"; bytes_out(3, 8'h69, 8'h69);
    cur_req = "R5_R8"; bytes_out(1, 8'h69, 8'h68);
    cur_req = "R7"; set_pol(1'b1);
    bytes_out(2, 8'h69, 8'h69);
    set_pol(1'b0);

    cur_req = "R9"; set_mode(2'b00);
    set_mode(2'b10);
    cur_req = "R4";
    for (int b = 0; b < 3; b++) drive(1'b0, '0, '0, 1'b1, 1'b1, 1'b1);
    cur_req = "R9"; set_mode(2'b00);
    set_mode(2'b10);
    cur_req = "R4"; bytes_out(7776, 8'h69, 8'h69);

    repeat (3) @(posedge clk);
    #2;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1: %0d expectations left unchecked, expected 0", q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule